// File: doc/BRIEF.md
# Time-Redundant Sampler with Retry

This block guards a register at the end of a combinational datapath against short transient pulses. It runs on a fast clock that splits each base period into a fixed number of ticks. The datapath result is captured twice in each period: once at the main sampling tick (tick 0) and once a programmable number of ticks later. A glitch shorter than that spacing can corrupt at most one of the two captures, so the two copies will differ.

The two captures are compared bit by bit on the tick after the late capture. If they agree, the value is committed to the output register and a one-cycle valid strobe is raised. If they differ, an error strobe is raised, the differing bits are reported, and a level retry request is asserted. The output register then keeps its earlier contents, much like a Muller C-element whose state changes only when both inputs match. The retry request stays high until a later period produces agreement. A build-time option selects word-wide hold (the default) or per-bit hold. With per-bit hold, each output bit behaves as its own C-element.

The cost is latency: a result is usable only after the late capture, so the spacing in ticks is both the widest pulse that can be detected and the time lost in each period.

Top module: `trs_sampler_top`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `held_out`, `mis_bits` equal to zero and `held_vld`, `mis_pulse`, `redo_req` low.
- R2: `samp_in` is captured at phase 0 (the first edge after reset release, then every TICKS edges) and again at phase DLY_TICKS. The comparison takes effect on the edge at phase DLY_TICKS+1. If the captures are equal, `held_out` takes the captured value and `held_vld` is high for exactly that one cycle.
- R3: If the two captures differ, `mis_pulse` is high for exactly one cycle, at the same point where `held_vld` would have been. During that cycle, `mis_bits` equals the bitwise XOR of the two captures, which is nonzero.
- R4: In word-hold mode (HOLD_MODE = HOLD_WORD, the default), a mismatch leaves `held_out` unchanged.
- R5: `redo_req` goes high with every `mis_pulse`. It stays high through any later mismatching periods and falls only in the cycle in which `held_vld` pulses.
- R6: `held_vld` and `mis_pulse` are never high together, and each comparison raises exactly one of them.
- R7: Values on `samp_in` at phases other than 0 and DLY_TICKS have no effect on any output.
- R8: In per-bit mode (HOLD_MODE = HOLD_BIT), on a mismatch each bit of `held_out` whose two captures agree takes the captured value, and each disagreeing bit keeps its previous value. `held_vld` still pulses only on full agreement.
- R9: Consecutive comparison results (`held_vld` or `mis_pulse`) are exactly TICKS cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast (oversampling) clock |
| rst | input | 1 | Synchronous active-high reset |
| samp_in | input | DW | Datapath result to be sampled |
| held_out | output | DW | Committed output register |
| held_vld | output | 1 | One-cycle strobe when a new agreed value is committed |
| mis_pulse | output | 1 | One-cycle strobe when the two captures differ |
| redo_req | output | 1 | Level request to repeat the computation |
| mis_bits | output | DW | Bits that differed in the latest comparison |

## Verification
The phase counter and the two capture registers cannot be seen directly. A wrong phase shows up as a wrong capture instant: values driven only at ignored phases then reach `held_out`, or the spacing of result strobes departs from TICKS. Either effect is visible within one base period. A stale or corrupted capture register produces a false `mis_pulse` or a wrong committed value at the very next comparison. A hold stage that loads on mismatch changes `held_out` in the same cycle as `mis_pulse`, and a retry flag that never clears is exposed by the first agreeing period that follows.

// File: rtl/trs_pkg.sv
package trs_pkg;

   // Selects how the output register reacts to a disagreeing comparison.
   typedef enum logic {
      HOLD_WORD = 1'b0,   // whole word frozen on any mismatch
      HOLD_BIT  = 1'b1    // each bit behaves as its own C-element
   } hold_mode_e;

endpackage

// File: rtl/trs_phase_gen.sv
module trs_phase_gen #(
   parameter int TICKS     = 8,
   parameter int DLY_TICKS = 3
) (
   input  logic clk,
   input  logic rst,
   output logic stb_early,
   output logic stb_late,
   output logic stb_cmp
);

   localparam int PW = (TICKS > 2) ? $clog2(TICKS) : 1;
   localparam logic [PW-1:0] PH_LAST = PW'(TICKS - 1);
   localparam logic [PW-1:0] PH_LATE = PW'(DLY_TICKS);

   logic [PW-1:0] ph_q;
   logic          cmp_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         ph_q <= '0;
      end else if (ph_q == PH_LAST) begin
         ph_q <= '0;
      end else begin
         ph_q <= ph_q + 1'b1;
      end
   end

   assign stb_early = (ph_q == '0);
   assign stb_late  = (ph_q == PH_LATE);

   // The comparison runs one tick after the late capture lands.
   always_ff @(posedge clk) begin
      if (rst) begin
         cmp_q <= 1'b0;
      end else begin
         cmp_q <= stb_late;
      end
   end

   assign stb_cmp = cmp_q;

endmodule

// File: rtl/trs_capture.sv
module trs_capture #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          stb_early,
   input  logic          stb_late,
   input  logic [DW-1:0] din,
   output logic [DW-1:0] cap_early,
   output logic [DW-1:0] cap_late
);

   always_ff @(posedge clk) begin
      if (rst) begin
         cap_early <= '0;
      end else if (stb_early) begin
         cap_early <= din;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cap_late <= '0;
      end else if (stb_late) begin
         cap_late <= din;
      end
   end

endmodule

// File: rtl/trs_hold_stage.sv
module trs_hold_stage
   import trs_pkg::*;
#(
   parameter int         DW        = 8,
   parameter hold_mode_e HOLD_MODE = HOLD_WORD
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          go,
   input  logic [DW-1:0] cap_early,
   input  logic [DW-1:0] cap_late,
   output logic [DW-1:0] out_q,
   output logic          vld_q,
   output logic          err_q,
   output logic          retry_q,
   output logic [DW-1:0] diff_q
);

   logic [DW-1:0] diff_w;
   logic          agree_w;

   assign diff_w  = cap_early ^ cap_late;
   assign agree_w = (diff_w == '0);

   // Result strobes and retry level.
   always_ff @(posedge clk) begin
      if (rst) begin
         vld_q   <= 1'b0;
         err_q   <= 1'b0;
         retry_q <= 1'b0;
         diff_q  <= '0;
      end else begin
         vld_q <= go & agree_w;
         err_q <= go & ~agree_w;
         if (go) begin
            diff_q  <= diff_w;
            retry_q <= ~agree_w;
         end
      end
   end

   // Output register variant.
   generate
      if (HOLD_MODE == HOLD_WORD) begin : g_word
         always_ff @(posedge clk) begin
            if (rst) begin
               out_q <= '0;
            end else if (go && agree_w) begin
               out_q <= cap_early;
            end
         end
      end else begin : g_bit
         for (genvar i = 0; i < DW; i++) begin : g_cel
            logic cel_q;
            always_ff @(posedge clk) begin
               if (rst) begin
                  cel_q <= 1'b0;
               end else if (go && !diff_w[i]) begin
                  cel_q <= cap_early[i];
               end
            end
            assign out_q[i] = cel_q;
         end
      end
   endgenerate

endmodule

// File: rtl/trs_sampler_top.sv
module trs_sampler_top
   import trs_pkg::*;
#(
   parameter int         DW        = 8,
   parameter int         TICKS     = 8,
   parameter int         DLY_TICKS = 3,
   parameter hold_mode_e HOLD_MODE = HOLD_WORD
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [DW-1:0] samp_in,
   output logic [DW-1:0] held_out,
   output logic          held_vld,
   output logic          mis_pulse,
   output logic          redo_req,
   output logic [DW-1:0] mis_bits
);

   // Elaboration-time parameter checks.
   generate
      if (DW < 1) begin : g_bad_dw
         $error("trs_sampler_top: DW must be at least 1");
      end
      if (TICKS < 2) begin : g_bad_ticks
         $error("trs_sampler_top: TICKS must be at least 2");
      end
      if (DLY_TICKS < 1 || DLY_TICKS >= TICKS) begin : g_bad_dly
         $error("trs_sampler_top: DLY_TICKS must lie in 1..TICKS-1");
      end
   endgenerate

   logic          stb_early;
   logic          stb_late;
   logic          stb_cmp;
   logic [DW-1:0] cap_early;
   logic [DW-1:0] cap_late;

   trs_phase_gen #(
      .TICKS     (TICKS),
      .DLY_TICKS (DLY_TICKS)
   ) phase_i (
      .clk       (clk),
      .rst       (rst),
      .stb_early (stb_early),
      .stb_late  (stb_late),
      .stb_cmp   (stb_cmp)
   );

   trs_capture #(
      .DW (DW)
   ) cap_i (
      .clk       (clk),
      .rst       (rst),
      .stb_early (stb_early),
      .stb_late  (stb_late),
      .din       (samp_in),
      .cap_early (cap_early),
      .cap_late  (cap_late)
   );

   trs_hold_stage #(
      .DW        (DW),
      .HOLD_MODE (HOLD_MODE)
   ) hold_i (
      .clk       (clk),
      .rst       (rst),
      .go        (stb_cmp),
      .cap_early (cap_early),
      .cap_late  (cap_late),
      .out_q     (held_out),
      .vld_q     (held_vld),
      .err_q     (mis_pulse),
      .retry_q   (redo_req),
      .diff_q    (mis_bits)
   );

endmodule

// File: rtl/trs_sampler_chk.sv
module trs_sampler_chk
   import trs_pkg::*;
#(
   parameter int         DW        = 8,
   parameter int         TICKS     = 8,
   parameter hold_mode_e HOLD_MODE = HOLD_WORD
) (
   input logic          clk,
   input logic          rst,
   input logic [DW-1:0] held_out,
   input logic          held_vld,
   input logic          mis_pulse,
   input logic          redo_req,
   input logic [DW-1:0] mis_bits
);

   localparam int CW = $clog2(TICKS + 1) + 1;

   logic          ev_w;
   logic          seen_q;
   logic [CW-1:0] gap_q;

   assign ev_w = held_vld | mis_pulse;

   always_ff @(posedge clk) begin
      if (rst) begin
         seen_q <= 1'b0;
         gap_q  <= '0;
      end else if (ev_w) begin
         seen_q <= 1'b1;
         gap_q  <= '0;
      end else if (gap_q != {CW{1'b1}}) begin
         gap_q <= gap_q + 1'b1;
      end
   end

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (held_out == '0 && mis_bits == '0 && !held_vld && !mis_pulse && !redo_req));

   // R2
   vld_single_chk: assert property (@(posedge clk) disable iff (rst)
      held_vld |=> !held_vld);

   // R3
   err_single_chk: assert property (@(posedge clk) disable iff (rst)
      mis_pulse |=> !mis_pulse);

   // R3
   err_bits_chk: assert property (@(posedge clk) disable iff (rst)
      mis_pulse |-> (mis_bits != '0));

   // R6
   vld_err_excl_chk: assert property (@(posedge clk) disable iff (rst)
      !(held_vld && mis_pulse));

   // R4
   word_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (HOLD_MODE == HOLD_WORD && mis_pulse) |-> $stable(held_out));

   // R5
   retry_on_err_chk: assert property (@(posedge clk) disable iff (rst)
      mis_pulse |-> redo_req);

   // R5
   retry_clear_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(redo_req) |-> held_vld);

   // R9
   result_spacing_chk: assert property (@(posedge clk) disable iff (rst)
      (ev_w && seen_q) |-> (gap_q == CW'(TICKS - 1)));

endmodule

bind trs_sampler_top trs_sampler_chk #(
   .DW        (DW),
   .TICKS     (TICKS),
   .HOLD_MODE (HOLD_MODE)
) chk_i (
   .clk       (clk),
   .rst       (rst),
   .held_out  (held_out),
   .held_vld  (held_vld),
   .mis_pulse (mis_pulse),
   .redo_req  (redo_req),
   .mis_bits  (mis_bits)
);

// File: tb/trs_sampler_top_tb_top.sv
module trs_sampler_top_tb_top;
   import trs_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int DW         = 8;
   localparam int TICKS      = 8;
   localparam int DLY        = 3;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [DW-1:0] din = '0;

   logic [DW-1:0] w_out,  b_out;
   logic          w_vld,  b_vld;
   logic          w_err,  b_err;
   logic          w_rty,  b_rty;
   logic [DW-1:0] w_bits, b_bits;

   int nchk  = 0;
   int nfail = 0;
   int cyc   = 0;
   int last_vld_cyc = 0;
   bit done  = 1'b0;
   logic [DW-1:0] prev_w = '0;
   logic [DW-1:0] prev_b = '0;

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   trs_sampler_top #(.DW(DW), .TICKS(TICKS), .DLY_TICKS(DLY), .HOLD_MODE(HOLD_WORD)) dut_i (
      .clk(clk), .rst(rst), .samp_in(din),
      .held_out(w_out), .held_vld(w_vld), .mis_pulse(w_err),
      .redo_req(w_rty), .mis_bits(w_bits));

   trs_sampler_top #(.DW(DW), .TICKS(TICKS), .DLY_TICKS(DLY), .HOLD_MODE(HOLD_BIT)) dut_bit_i (
      .clk(clk), .rst(rst), .samp_in(din),
      .held_out(b_out), .held_vld(b_vld), .mis_pulse(b_err),
      .redo_req(b_rty), .mis_bits(b_bits));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // Starts just before a phase-0 edge; returns just after the compare edge.
   task automatic drive_period(input logic [DW-1:0] a, input logic [DW-1:0] b,
                               input logic [DW-1:0] mid);
      din = a;   @(negedge clk);               // phase 0 captured
      din = mid; @(negedge clk); @(negedge clk);
      din = b;   @(negedge clk);               // phase DLY captured
      din = mid; @(negedge clk);               // compare edge passed
   endtask

   task automatic finish_period();
      @(negedge clk);
      check("R2 valid one cycle", w_vld, 0);
      check("R3 error one cycle", w_err, 0);
      @(negedge clk); @(negedge clk);
   endtask

   task automatic t_reset();
      rst = 1'b1; din = 8'hFF;
      repeat (3) @(negedge clk);
      check("R1 out", w_out, 0);
      check("R1 bits", w_bits, 0);
      check("R1 flags", {w_vld, w_err, w_rty}, 0);
      rst = 1'b0;
      prev_w = '0; prev_b = '0;
   endtask

   task automatic t_agree(input logic [DW-1:0] v);
      drive_period(v, v, v);
      check("R2 out", w_out, v);
      check("R2 valid", w_vld, 1);
      check("R6 no error", w_err, 0);
      check("R5 retry cleared", w_rty, 0);
      check("R8 bit-mode out on agree", b_out, v);
      last_vld_cyc = cyc;
      prev_w = v; prev_b = v;
      finish_period();
   endtask

   task automatic t_mismatch(input logic [DW-1:0] a, input logic [DW-1:0] b);
      logic [DW-1:0] d;
      logic [DW-1:0] exp_b;
      d = a ^ b;
      exp_b = (prev_b & d) | (a & ~d);
      drive_period(a, b, a);
      check("R3 error", w_err, 1);
      check("R3 diff bits", w_bits, d);
      check("R6 no valid", w_vld, 0);
      check("R4 word hold", w_out, prev_w);
      check("R5 retry", w_rty, 1);
      check("R8 bit hold", b_out, exp_b);
      check("R8 bit valid low", b_vld, 0);
      prev_b = exp_b;
      finish_period();
      check("R5 retry held", w_rty, 1);
   endtask

   task automatic t_ignore(input logic [DW-1:0] v, input logic [DW-1:0] junk);
      drive_period(v, v, junk);
      check("R7 junk ignored out", w_out, v);
      check("R7 junk no error", w_err, 0);
      check("R7 junk valid", w_vld, 1);
      prev_w = v; prev_b = v;
      finish_period();
   endtask

   task automatic t_spacing();
      int first;
      t_agree(8'h11);
      first = last_vld_cyc;
      t_agree(8'h22);
      check("R9 result spacing", last_vld_cyc - first, TICKS);
   endtask

   initial begin
      t_reset();
      t_agree(8'hA5);
      t_mismatch(8'h3C, 8'h3F);
      t_mismatch(8'h80, 8'h00);
      t_agree(8'h5A);
      t_ignore(8'hC3, 8'h18);
      t_spacing();
      t_mismatch(8'hF0, 8'h0F);
      t_reset();
      @(negedge clk);
      check("R1 state after second reset", {w_out, w_vld, w_err, w_rty}, 0);
      repeat (TICKS - 1) @(negedge clk);
      t_agree(8'h77);
      done = 1'b1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         nchk++; nfail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", nchk - nfail, nchk);
         $finish;
      end
   end

endmodule